// File: doc/BRIEF.md
# Full-Speed Serial Bus Line Receiver

This block sits directly behind the two single-ended data lines of a full-speed (12 Mbit/s) serial bus. The lines are sampled synchronously at four times the bit rate. The block turns the line activity of each packet back into the serial data bit stream. It sorts every sample into one of four line states and discards isolated one-sample spikes. It then measures how many samples each accepted state lasts. From that run length it derives the number of bit periods. One measurement drives the NRZI decode, the removal of stuffed bits and the choice between end-of-packet and bus reset.

Decoded bits leave one per clock on a valid strobe, in the order they crossed the wire, starting with the eight synchronisation bits. A packet-active flag spans each packet. Single-cycle pulses report end-of-packet, bus reset and line errors. The outputs can feed a packet parser directly. There is no handshake: the downstream logic must accept one bit on every cycle in which the strobe is high.

Top module: `fsrx_line_rx`

## Requirements
- R1: A sample is classified from {line_p, line_n}: 2'b10 is J, 2'b01 is K, 2'b00 is SE0 and 2'b11 is SE1. An accepted SE1 state raises err_pls for one clock and produces no data bits.
- R2: Inside a packet, each change between J and K yields a 0 bit. Each further bit period spent in the same J or K state yields a 1 bit.
- R3: A 0 that follows exactly six consecutive 1 bits is a stuffed bit. It is removed and never appears on bit_dat.
- R4: A J or K run inside a packet that carries more than six 1 bits raises err_pls for one clock. The 1 bits of that run are discarded.
- R5: An SE0 shorter than RST_SAMPLES (10) samples that ends while a packet is active gives exactly one eop_pls and drops pkt_act. An SE0 outside a packet gives no eop_pls.
- R6: An SE0 that lasts RST_SAMPLES samples gives exactly one bus_rst_pls, clears pkt_act and the pending bits, and gives no eop_pls.
- R7: A line state that lasts a single sample is ignored. It neither ends a run nor starts a packet.
- R8: While the bus idles in J, no bits are produced. The first change from idle to K sets pkt_act, and that change is the first 0 bit.
- R9: A run of s samples counts as (s+2)/4 bit periods, rounded down. A packet whose bits last 3 or 5 samples each therefore decodes the same as one with 4-sample bits.
- R10: bit_vld is high for exactly one clock per decoded bit, with bit_dat in wire order, including the eight synchronisation bits 0000_0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, four times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_p | input | 1 | Positive data line sample |
| line_n | input | 1 | Negative data line sample |
| bit_vld | output | 1 | One-clock strobe per decoded data bit |
| bit_dat | output | 1 | Decoded data bit, valid with bit_vld |
| pkt_act | output | 1 | High from the first transition out of idle until end-of-packet or bus reset |
| eop_pls | output | 1 | One-clock end-of-packet pulse |
| bus_rst_pls | output | 1 | One-clock bus-reset pulse |
| err_pls | output | 1 | One-clock pulse on a bit-stuff violation or an SE1 line state |

## Verification
The bench feeds payloads with long strings of ones through its own stuffing NRZI encoder. A receiver that kept the stuffed zero would return extra 0 bits, and one that counted ones across a transition would drop real zeros. A spike in the middle of a bit and one in idle J are both applied: a missing glitch filter would split a run and insert a bit, or would open a false packet. Bits of 3 and 5 samples check the rounding, since truncating division would lose a 1 bit on short runs. SE0 lengths of 9 and 10 samples bracket the boundary between end-of-packet and bus reset. A design that got this boundary wrong would report both pulses or the wrong one. A held state of eight bit periods must raise the error instead of passing seven 1 bits.

// File: rtl/fsrx_pkg.sv
package fsrx_pkg;

  // Line state, encoded as {line_p, line_n}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  function automatic logic is_data(line_e s);
    return (s == LS_J) || (s == LS_K);
  endfunction

endpackage

// File: rtl/fsrx_linefilt.sv
// Input register, single-sample spike rejection and run-length counter.
module fsrx_linefilt
  import fsrx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_p,
  input  logic             line_n,
  output line_e            filt_st,
  output logic             ev,
  output line_e            ev_old,
  output line_e            ev_new,
  output logic [CNT_W-1:0] run_len
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  line_e            raw_q, cand_q, filt_q;
  line_e            raw_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;

  // A new state is taken only once two consecutive samples agree on it.
  always_comb begin
    raw_d  = line_e'({line_p, line_n});
    accept = (raw_q == cand_q) && (raw_q != filt_q);
    if (accept)
      cnt_d = CNT_ONE;
    else if (cnt_q == CNT_MAX)
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= LS_J;
      cand_q <= LS_J;
      filt_q <= LS_J;
      cnt_q  <= '0;
    end else begin
      raw_q  <= raw_d;
      cand_q <= raw_q;
      if (accept) filt_q <= raw_q;
      cnt_q  <= cnt_d;
    end
  end

  assign filt_st = filt_q;
  assign ev      = accept;
  assign ev_old  = filt_q;
  assign ev_new  = raw_q;
  assign run_len = cnt_q;

endmodule

// File: rtl/fsrx_runcode.sv
// Turns each finished run into decoded bits and packet events.
module fsrx_runcode
  import fsrx_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int RST_SAMPLES = 10,
  parameter int STUFF_RUN   = 6,
  parameter int PW          = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  line_e            filt_st,
  input  logic             ev,
  input  line_e            ev_old,
  input  line_e            ev_new,
  input  logic [CNT_W-1:0] run_len,
  output logic [PW-1:0]    push_n,
  output logic [PW-1:0]    push_ones,
  output logic             q_clr,
  output logic             pkt_act,
  output logic             eop_pls,
  output logic             bus_rst_pls,
  output logic             err_pls
);

  localparam int LW = CNT_W + 1;
  localparam logic [LW-1:0]    STUFF_L = LW'(STUFF_RUN);
  localparam logic [CNT_W-1:0] RST_L   = CNT_W'(RST_SAMPLES);

  logic [LW-1:0] nbits, ones;
  logic          to_data, rst_hit;
  logic          act_q, act_d;
  logic          eop_q, eop_d;
  logic          rst_q, rst_d;
  logic          err_q, err_d;

  always_comb begin
    nbits     = ({1'b0, run_len} + LW'(2)) >> 2;
    ones      = (nbits == '0) ? '0 : nbits - LW'(1);
    to_data   = is_data(ev_new);
    rst_hit   = (filt_st == LS_SE0) && (run_len == RST_L);
    act_d     = act_q;
    eop_d     = 1'b0;
    rst_d     = 1'b0;
    err_d     = 1'b0;
    q_clr     = 1'b0;
    push_n    = '0;
    push_ones = '0;

    if (ev) begin
      if (ev_new == LS_SE1) begin
        err_d = 1'b1;
      end else if (ev_old == LS_SE0) begin
        if (act_q && (run_len < RST_L)) eop_d = 1'b1;
        act_d = 1'b0;
      end else if (ev_old == LS_SE1) begin
        act_d = act_q;
      end else if (!act_q) begin
        // leaving idle: the change itself is the first 0 bit
        if (to_data) begin
          act_d  = 1'b1;
          push_n = PW'(1);
        end
      end else if (ones > STUFF_L) begin
        err_d  = 1'b1;
        push_n = PW'(to_data);
      end else if (ones == STUFF_L) begin
        // the closing change is a stuffed zero: drop it
        push_n    = PW'(ones);
        push_ones = PW'(ones);
      end else begin
        push_n    = PW'(ones) + PW'(to_data);
        push_ones = PW'(ones);
      end
    end

    if (rst_hit) begin
      rst_d  = 1'b1;
      eop_d  = 1'b0;
      act_d  = 1'b0;
      q_clr  = 1'b1;
      push_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      eop_q <= 1'b0;
      rst_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      act_q <= act_d;
      eop_q <= eop_d;
      rst_q <= rst_d;
      err_q <= err_d;
    end
  end

  assign pkt_act     = act_q;
  assign eop_pls     = eop_q;
  assign bus_rst_pls = rst_q;
  assign err_pls     = err_q;

endmodule

// File: rtl/fsrx_bitq.sv
// Small bit queue: a burst of up to seven bits in, one bit out per clock.
module fsrx_bitq #(
  parameter int Q_DEPTH = 16,
  parameter int PW      = 3,
  parameter int QCW     = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PW-1:0]  push_n,
  input  logic [PW-1:0]  push_ones,
  input  logic           clr,
  output logic           bit_vld,
  output logic           bit_dat,
  output logic [QCW-1:0] q_cnt
);

  localparam int CW1 = QCW + 1;

  logic [Q_DEPTH-1:0] q_bits, base_bits, q_d;
  logic [QCW-1:0]     cnt_q;
  logic [CW1-1:0]     base_cnt, cnt_d;
  logic               pop;

  always_comb begin
    pop       = (cnt_q != '0);
    base_bits = pop ? (q_bits >> 1) : q_bits;
    base_cnt  = {1'b0, cnt_q} - CW1'(pop);
    q_d       = base_bits;
    for (int i = 0; i < Q_DEPTH; i++) begin
      if ((CW1'(i) >= base_cnt) && (CW1'(i) < base_cnt + CW1'(push_n)))
        q_d[i] = (CW1'(i) - base_cnt) < CW1'(push_ones);
    end
    cnt_d = clr ? '0 : base_cnt + CW1'(push_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_bits <= '0;
      cnt_q  <= '0;
    end else begin
      q_bits <= q_d;
      cnt_q  <= QCW'(cnt_d);
    end
  end

  assign bit_vld = pop;
  assign bit_dat = q_bits[0];
  assign q_cnt   = cnt_q;

endmodule

// File: rtl/fsrx_line_rx.sv
module fsrx_line_rx
  import fsrx_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int RST_SAMPLES = 10,
  parameter int STUFF_RUN   = 6,
  parameter int Q_DEPTH     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_p,
  input  logic line_n,
  output logic bit_vld,
  output logic bit_dat,
  output logic pkt_act,
  output logic eop_pls,
  output logic bus_rst_pls,
  output logic err_pls
);

  localparam int PW  = $clog2(STUFF_RUN + 2);
  localparam int QCW = $clog2(Q_DEPTH + 1);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  line_e            filt_st, ev_old, ev_new;
  logic             ev;
  logic [CNT_W-1:0] run_len;
  logic [PW-1:0]    push_n, push_ones;
  logic             q_clr;
  logic [QCW-1:0]   q_cnt;

  // reset asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  fsrx_linefilt #(.CNT_W(CNT_W)) u_filt (
    .clk(clk), .rst_n(rst_int_n), .line_p(line_p), .line_n(line_n),
    .filt_st(filt_st), .ev(ev), .ev_old(ev_old), .ev_new(ev_new),
    .run_len(run_len)
  );

  fsrx_runcode #(
    .CNT_W(CNT_W), .RST_SAMPLES(RST_SAMPLES), .STUFF_RUN(STUFF_RUN), .PW(PW)
  ) u_code (
    .clk(clk), .rst_n(rst_int_n), .filt_st(filt_st), .ev(ev),
    .ev_old(ev_old), .ev_new(ev_new), .run_len(run_len),
    .push_n(push_n), .push_ones(push_ones), .q_clr(q_clr),
    .pkt_act(pkt_act), .eop_pls(eop_pls), .bus_rst_pls(bus_rst_pls),
    .err_pls(err_pls)
  );

  fsrx_bitq #(.Q_DEPTH(Q_DEPTH), .PW(PW), .QCW(QCW)) u_q (
    .clk(clk), .rst_n(rst_int_n), .push_n(push_n), .push_ones(push_ones),
    .clr(q_clr), .bit_vld(bit_vld), .bit_dat(bit_dat), .q_cnt(q_cnt)
  );

endmodule

// File: rtl/fsrx_line_rx_chk.sv
module fsrx_line_rx_chk #(
  parameter int Q_DEPTH = 16,
  parameter int QCW     = 5,
  parameter int PW      = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bit_vld,
  input logic           pkt_act,
  input logic           eop_pls,
  input logic           bus_rst_pls,
  input logic           err_pls,
  input logic [QCW-1:0] q_cnt,
  input logic [PW-1:0]  push_n
);

  localparam int CW1 = QCW + 1;

  assert_sop_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_act) |-> bit_vld);

  assert_eop_ends_pkt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eop_pls |-> (!pkt_act && $past(pkt_act)));

  assert_eop_rst_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eop_pls, bus_rst_pls}));

  assert_rst_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_pls |-> (!pkt_act && !bit_vld));

  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_pls |=> !bus_rst_pls);

  assert_err_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_pls |=> !err_pls);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, q_cnt} + CW1'(push_n)) <= CW1'(Q_DEPTH)));

endmodule

bind fsrx_line_rx fsrx_line_rx_chk #(.Q_DEPTH(Q_DEPTH), .QCW(QCW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .pkt_act(pkt_act),
  .eop_pls(eop_pls), .bus_rst_pls(bus_rst_pls), .err_pls(err_pls),
  .q_cnt(q_cnt), .push_n(push_n)
);

// File: tb/fsrx_line_rx_bench.sv
module fsrx_line_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] LJ = 2'b10, LK = 2'b01, LSE0 = 2'b00, LSE1 = 2'b11;

  // {byte count, byte2, byte1, byte0}; bytes go out LSB first
  localparam logic [31:0] VEC [0:5] = '{
    32'h010000A5, 32'h0200FFFF, 32'h033F7E00,
    32'h01000000, 32'h0200FC80, 32'h03C3813F
  };

  logic clk = 1'b0, rst_n = 1'b0, line_p = 1'b1, line_n = 1'b0;
  logic bit_vld, bit_dat, pkt_act, eop_pls, bus_rst_pls, err_pls;

  int n_chk = 0, n_bad = 0;
  int tot_bits = 0, tot_eop = 0, tot_rst = 0, tot_err = 0;
  logic cap_all [0:4095];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsrx_line_rx u_fsrx_line_rx (
    .clk(clk), .rst_n(rst_n), .line_p(line_p), .line_n(line_n),
    .bit_vld(bit_vld), .bit_dat(bit_dat), .pkt_act(pkt_act),
    .eop_pls(eop_pls), .bus_rst_pls(bus_rst_pls), .err_pls(err_pls)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_vld) begin
        if (tot_bits < 4096) cap_all[tot_bits] <= bit_dat;
        tot_bits <= tot_bits + 1;
      end
      if (eop_pls)     tot_eop <= tot_eop + 1;
      if (bus_rst_pls) tot_rst <= tot_rst + 1;
      if (err_pls)     tot_err <= tot_err + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] s);
    @(negedge clk);
    line_p = s[1];
    line_n = s[0];
  endtask

  task automatic put_n(input logic [1:0] s, input int n);
    for (int k = 0; k < n; k++) put(s);
  endtask

  task automatic put_bit(input logic [1:0] lv, input int nsmp, input bit glitch);
    for (int k = 0; k < nsmp; k++) put((glitch && k == 2) ? ~lv : lv);
  endtask

  // Encode sync + payload with stuffing and NRZI, then end with SE0.
  task automatic send(input int nbytes, input logic [23:0] data, input bit jit,
                      input int gbit, input int se0_len,
                      output logic [31:0] expw, output int nexp, output bit act_seen);
    logic [1:0] lv = LJ;
    int ones = 0;
    int wb = 0;
    nexp = 8 + 8 * nbytes;
    expw = '0;
    expw[7] = 1'b1;
    for (int i = 0; i < 8 * nbytes; i++) expw[8+i] = data[i];
    act_seen = 1'b0;
    put_n(LJ, 6);
    for (int i = 0; i < nexp; i++) begin
      if (!expw[i]) begin lv = ~lv; ones = 0; end
      else ones++;
      put_bit(lv, jit ? ((wb % 2 == 1) ? 3 : 5) : 4, i == gbit);
      wb++;
      if (i == 9) act_seen = pkt_act;
      if (ones == 6) begin
        lv = ~lv;
        ones = 0;
        put_bit(lv, jit ? ((wb % 2 == 1) ? 3 : 5) : 4, 1'b0);
        wb++;
      end
    end
    put_n(LSE0, se0_len);
    put_n(LJ, 20);
  endtask

  function automatic logic [31:0] grab(input int base, input int n);
    logic [31:0] w = '0;
    for (int i = 0; i < n && i < 32; i++)
      if (base + i < 4096) w[i] = cap_all[base + i];
    return w;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] expw;
    int nexp, b0, e0, r0, x0;
    bit act_seen;

    put_n(LJ, 5);
    // reset state (R8 R10)
    chk(!bit_vld && !pkt_act, "R8 reset outputs", {bit_vld, pkt_act}, 0);
    chk(!eop_pls && !bus_rst_pls && !err_pls, "R10 reset pulses",
        {eop_pls, bus_rst_pls, err_pls}, 0);
    rst_n = 1'b1;
    put_n(LJ, 8);

    // table of packets
    for (int v = 0; v < 6; v++) begin
      b0 = tot_bits; e0 = tot_eop; r0 = tot_rst; x0 = tot_err;
      send(int'(VEC[v][31:24]), VEC[v][23:0], 1'b0, -1, 8, expw, nexp, act_seen);
      chk(tot_bits - b0 == nexp, "R10 bit count", tot_bits - b0, nexp);
      chk(grab(b0, nexp) == expw, "R2 R3 bit values", grab(b0, nexp), expw);
      chk(tot_eop - e0 == 1 && !pkt_act, "R5 eop", tot_eop - e0, 1);
      chk(tot_err - x0 == 0 && tot_rst - r0 == 0, "R4 no error", tot_err - x0, 0);
      chk(act_seen, "R8 packet active", act_seen, 1);
    end

    // spike in idle, and SE1 spike (R7)
    b0 = tot_bits; x0 = tot_err;
    put(LK); put_n(LJ, 6); put(LSE1); put_n(LJ, 12);
    chk(tot_bits == b0 && !pkt_act, "R7 idle spike", tot_bits - b0, 0);
    chk(tot_err == x0, "R7 SE1 spike", tot_err - x0, 0);

    // held SE1 (R1)
    b0 = tot_bits; x0 = tot_err;
    put_n(LSE1, 3); put_n(LJ, 12);
    chk(tot_err - x0 == 1, "R1 SE1 error", tot_err - x0, 1);
    chk(tot_bits == b0, "R1 SE1 no bits", tot_bits - b0, 0);

    // spike inside a bit (R7)
    b0 = tot_bits;
    send(1, 24'h0000A5, 1'b0, 12, 8, expw, nexp, act_seen);
    chk(grab(b0, nexp) == expw && tot_bits - b0 == nexp, "R7 mid-bit spike",
        grab(b0, nexp), expw);

    // bit widths of 5 and 3 samples (R9)
    b0 = tot_bits;
    send(2, 24'h003CFF, 1'b1, -1, 8, expw, nexp, act_seen);
    chk(tot_bits - b0 == nexp, "R9 jitter count", tot_bits - b0, nexp);
    chk(grab(b0, nexp) == expw, "R9 jitter bits", grab(b0, nexp), expw);

    // bus reset from idle (R6)
    e0 = tot_eop; r0 = tot_rst;
    put_n(LSE0, 16); put_n(LJ, 12);
    chk(tot_rst - r0 == 1 && tot_eop == e0, "R6 idle reset", tot_rst - r0, 1);

    // SE0 of 10 samples inside a packet (R6)
    e0 = tot_eop; r0 = tot_rst;
    send(1, 24'h0000A5, 1'b0, -1, 10, expw, nexp, act_seen);
    chk(tot_rst - r0 == 1, "R6 reset at threshold", tot_rst - r0, 1);
    chk(tot_eop == e0 && !pkt_act, "R6 no eop on reset", tot_eop - e0, 0);

    // SE0 of 9 samples is still end-of-packet (R5)
    e0 = tot_eop; r0 = tot_rst;
    send(1, 24'h00003C, 1'b0, -1, 9, expw, nexp, act_seen);
    chk(tot_eop - e0 == 1 && tot_rst == r0, "R5 eop below threshold", tot_eop - e0, 1);

    // short SE0 outside a packet (R5)
    e0 = tot_eop; r0 = tot_rst;
    put_n(LSE0, 8); put_n(LJ, 12);
    chk(tot_eop == e0 && tot_rst == r0, "R5 idle SE0", tot_eop - e0, 0);

    // held K for eight bit periods: seven ones (R4)
    b0 = tot_bits; x0 = tot_err; e0 = tot_eop;
    put_n(LJ, 4); put_n(LK, 32); put_n(LJ, 4); put_n(LSE0, 8); put_n(LJ, 12);
    chk(tot_err - x0 == 1, "R4 stuff error", tot_err - x0, 1);
    chk(tot_bits - b0 == 2, "R4 ones discarded", tot_bits - b0, 2);
    chk(tot_eop - e0 == 1, "R5 eop after error", tot_eop - e0, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule